// File: doc/BRIEF.md
# Interleaved dual-channel input demultiplexer

This block sits in front of a pair of converter cores. In interleaved mode one 14-bit bus carries words for two channels in turn. A select line steers each written word into the channel-A or channel-B input register. The register that is not selected holds its contents by reloading its own value. A falling write strobe moves both input registers into a staging pair. The two output words are loaded from that staging pair together, on the rising edge of an update clock. The update clock is the input clock divided by two, so the cores run at half the bus word rate.

An alignment input holds the divided clock low. When it is released, the next input-clock edge produces the first rising edge of the divided clock. The position of the update edge is therefore fixed relative to the staged pair, and an A word and a B word written together always leave the block together. When the mode input is high, the block runs in dual-bus mode instead. Each channel takes its own bus, select and alignment have no effect, and the outputs reload on every input-clock edge.

Top module: `ilv_demux`

## Requirements
- R1: While rst_n is low, dac_a, dac_b and dac_clk are all zero.
- R2: After an edge that samples align high, dac_clk is 0 and neither output word changes.
- R3: With mode=0, the first edge that samples align low drives dac_clk to 1. Each later edge with align low inverts it.
- R4: mode=0 selects interleaved operation. On an edge with wr=1, bus_a is loaded into the channel-A input register when sel=1 and into the channel-B input register when sel=0. bus_b has no effect in this mode.
- R5: In interleaved mode, the input register that is not selected keeps its previous value.
- R6: An edge that samples wr=0, after an edge that sampled wr=1, copies both input registers into the staging pair. While wr stays high, no new word reaches the outputs.
- R7: With mode=0, dac_a and dac_b are loaded from the staging pair together, and only at an edge where dac_clk rises. This includes the first such edge after reset.
- R8: mode=1 selects dual-bus operation. On each edge with wr=1, bus_a goes to the A input register and bus_b goes to the B input register. Each edge then copies both input registers to dac_a and dac_b, so a word reaches its output two edges after it is driven. sel and align have no effect, and dac_clk stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 = interleaved, 1 = dual-bus |
| align | input | 1 | Phase-alignment reset for the divided clock |
| wr | input | 1 | Write strobe, sampled on clk |
| sel | input | 1 | Interleaved channel select, 1 = A, 0 = B |
| bus_a | input | W | Shared bus (interleaved) or channel-A bus |
| bus_b | input | W | Channel-B bus (dual-bus mode only) |
| dac_a | output | W | Channel-A word to its converter core |
| dac_b | output | W | Channel-B word to its converter core |
| dac_clk | output | 1 | Divided update clock |

## Verification
The assertions check on every cycle that alignment holds the divided clock low, that the clock toggles once alignment is released, and that it stays low in dual-bus mode. They also check that an interleaved output word can only change at a rising edge of the divided clock. Only the bench scenarios can show that the right word lands in the right channel. The same goes for the unselected channel holding its value, a held-high strobe keeping new data back, and the two-edge path in dual-bus mode.

// File: rtl/ilv_demux.sv
module ilv_demux #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode,
  input  logic         align,
  input  logic         wr,
  input  logic         sel,
  input  logic [W-1:0] bus_a,
  input  logic [W-1:0] bus_b,
  output logic [W-1:0] dac_a,
  output logic [W-1:0] dac_b,
  output logic         dac_clk
);

  logic [W-1:0] in_a, in_b, stg_a, stg_b;
  logic         wr_q, dclk;

  wire          wr_fall = wr_q & ~wr;
  wire          load    = mode | (~align & ~dclk);
  wire  [W-1:0] src_a   = mode ? in_a : stg_a;
  wire  [W-1:0] src_b   = mode ? in_b : stg_b;

  assign dac_clk = dclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_a  <= '0;
      in_b  <= '0;
      stg_a <= '0;
      stg_b <= '0;
      wr_q  <= 1'b0;
      dclk  <= 1'b0;
      dac_a <= '0;
      dac_b <= '0;
    end else begin
      wr_q <= wr;
      if (wr) begin
        if (mode) begin
          in_a <= bus_a;
          in_b <= bus_b;
        end else if (sel) begin
          in_a <= bus_a;
        end else begin
          in_b <= bus_a;
        end
      end
      if (wr_fall) begin
        stg_a <= in_a;
        stg_b <= in_b;
      end
      dclk <= (mode | align) ? 1'b0 : ~dclk;
      if (load) begin
        dac_a <= src_a;
        dac_b <= src_b;
      end
    end
  end

endmodule

// File: rtl/ilv_demux_sva.sv
module ilv_demux_sva #(
  parameter int W = 14
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode,
  input logic         align,
  input logic [W-1:0] dac_a,
  input logic [W-1:0] dac_b,
  input logic         dac_clk
);

  assert_clk_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    align |=> !dac_clk);

  assert_clk_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!align && !mode) |=> (dac_clk != $past(dac_clk)));

  assert_paired_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mode) && (!$stable(dac_a) || !$stable(dac_b))) |-> $rose(dac_clk));

  assert_dual_clk_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode |=> !dac_clk);

endmodule

bind ilv_demux ilv_demux_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .mode(mode), .align(align),
  .dac_a(dac_a), .dac_b(dac_b), .dac_clk(dac_clk)
);

// File: tb/ilv_demux_test.sv
module ilv_demux_test;
  localparam int W = 14;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0, align = 1'b1, wr = 1'b0, sel = 1'b0;
  logic [W-1:0] bus_a = '0, bus_b = '0;
  logic [W-1:0] dac_a, dac_b;
  logic dac_clk;

  int vectors = 0, miscompares = 0;
  logic mon_on = 1'b0;
  logic [2*W-1:0] expq[$];
  logic [W-1:0] pa = '0, pb = '0, cur_b = '0;

  always #10 clk = ~clk;

  ilv_demux #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .align(align), .wr(wr), .sel(sel),
    .bus_a(bus_a), .bus_b(bus_b), .dac_a(dac_a), .dac_b(dac_b), .dac_clk(dac_clk)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(negedge clk) begin
    if (mon_on && (dac_a !== pa || dac_b !== pb)) begin
      if (expq.size() == 0) begin
        chk("R7 unexpected output change", {4'h0, dac_a, dac_b}, {4'h0, pa, pb});
      end else begin
        logic [2*W-1:0] e;
        e = expq.pop_front();
        chk("R4 R5 R6 pair", {4'h0, dac_a, dac_b}, {4'h0, e});
        chk("R7 change on dac_clk rise", {31'h0, dac_clk}, 32'h1);
      end
    end
    pa = dac_a;
    pb = dac_b;
  end

  task automatic write_word(input logic s, input logic [W-1:0] w);
    wr = 1'b1; sel = s; bus_a = w; bus_b = 14'h1555;
    @(negedge clk);
    wr = 1'b0; bus_b = 14'h2AAA;
    @(negedge clk);
  endtask

  task automatic load_pair(input logic [W-1:0] a, input logic [W-1:0] b, input logic wb);
    align = 1'b1;
    @(negedge clk);
    write_word(1'b1, a);
    if (wb) begin
      write_word(1'b0, b);
      cur_b = b;
    end
    expq.push_back({a, cur_b});
    align = 1'b0;
    @(negedge clk);
    chk("R3 first rise", {31'h0, dac_clk}, 32'h1);
    @(negedge clk);
    chk("R3 toggle low", {31'h0, dac_clk}, 32'h0);
    @(negedge clk);
    chk("R3 toggle high", {31'h0, dac_clk}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dac_a", {18'h0, dac_a}, 32'h0);
    chk("R1 dac_b", {18'h0, dac_b}, 32'h0);
    chk("R1 dac_clk", {31'h0, dac_clk}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 clk held low", {31'h0, dac_clk}, 32'h0);
    chk("R2 outputs untouched", {4'h0, dac_a, dac_b}, 32'h0);
    mon_on = 1'b1;

    load_pair(14'h1234, 14'h0ABC, 1'b1);
    load_pair(14'h3FFF, 14'h0001, 1'b1);
    load_pair(14'h0222, 14'h0000, 1'b0);

    wr = 1'b1; sel = 1'b1; bus_a = 14'h2D2D;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R6 strobe high holds dac_a", {18'h0, dac_a}, {18'h0, 14'h0222});
    end
    expq.push_back({14'h2D2D, cur_b});
    wr = 1'b0;
    repeat (4) @(negedge clk);

    load_pair(14'h0000, 14'h3FFF, 1'b1);
    repeat (2) @(negedge clk);
    chk("R7 all pairs delivered", expq.size(), 32'h0);
    mon_on = 1'b0;

    mode = 1'b1; align = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i >= 2) begin
        chk("R8 dual dac_a", {18'h0, dac_a}, {18'h0, 14'(14'h0100 + (i - 2) * 3)});
        chk("R8 dual dac_b", {18'h0, dac_b}, {18'h0, 14'(14'h2A00 + (i - 2))});
        chk("R8 dac_clk low", {31'h0, dac_clk}, 32'h0);
      end
      wr = 1'b1; sel = i[0]; align = i[1];
      bus_a = 14'(14'h0100 + i * 3);
      bus_b = 14'(14'h2A00 + i);
      @(negedge clk);
    end
    wr = 1'b0; bus_a = 14'h3333; bus_b = 14'h0444;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R8 no write holds dac_a", {18'h0, dac_a}, {18'h0, 14'(14'h0100 + 7 * 3)});
      chk("R8 no write holds dac_b", {18'h0, dac_b}, {18'h0, 14'(14'h2A00 + 7)});
      @(negedge clk);
    end
    finish_run();
  end
endmodule